// File: doc/BRIEF.md
# Four-address memory-to-memory sequencer

This block is a processor core with no architectural registers. Each instruction carries an opcode and four addresses: where the result goes, where the two source operands are, and where the following instruction starts. The core fetches the instruction from a single-port synchronous memory one data word at a time. It then reads both operands, applies the operation and writes the result back to memory. Finally it continues at the address held in the instruction's own next-address field.

Software loads a program and its data into memory, presents a start address and pulses `start`. The core runs until it reaches a halt instruction or an unknown opcode, and then raises `halted`. The instruction is packed from the top of the first word downward in this order: opcode (`OPC_W` bits), result address, first-operand address, second-operand address, next address (`ADDR_W` bits each). Unused low bits of the last word are ignored. With the defaults of 32-bit data and 24-bit addresses, the 104-bit instruction fills four words.

Top module: `mm4_core`

## Requirements
- R1: While reset is held and afterwards until the first start, `halted` is 1, `illegal_op` is 0 and `mem_we` is 0.
- R2: A cycle with `start` high makes the core fetch from `start_addr` in the next cycle, and clears `halted` and `illegal_op` in that cycle. This applies in any state, including mid-instruction.
- R3: An instruction at address I is fetched as `BEATS = ceil((OPC_W+4*ADDR_W)/DATA_W)` reads of addresses I, I+1, ... I+BEATS-1 on consecutive cycles. Word I holds the most significant bits.
- R4: Opcode 0x01 writes (word[first] + word[second]) mod 2^DATA_W to the result address.
- R5: Opcode 0x02 writes (word[first] - word[second]) mod 2^DATA_W to the result address.
- R6: Opcode 0x03 writes the low DATA_W bits of word[first] * word[second] to the result address.
- R7: The next instruction is fetched from the next-address field only. Nothing placed at the sequentially following address is executed.
- R8: Opcode 0x00 stops the core with `halted`=1, `illegal_op`=0 and no memory write.
- R9: Any opcode other than 0x00 to 0x03 stops the core with `halted`=1 and `illegal_op`=1, and does not write the result address.
- R10: A computing instruction performs exactly one write, lasting one cycle. It occurs BEATS+4 cycles after the instruction's first fetch cycle and goes to the result address. A whole instruction takes BEATS+6 cycles.
- R11: Both operands are read before the result is written, so a result address equal to an operand address receives the value computed from the old operand.
- R12: A start issued while an instruction is in progress abandons that instruction without writing its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin execution at `start_addr` |
| start_addr | input | ADDR_W | Address of the first instruction |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |
| halted | output | 1 | Core is stopped |
| illegal_op | output | 1 | Core stopped on an unknown opcode |

## Verification
The bench builds the core with 4-bit data words and 8-bit addresses. An instruction then spans ten words and the opcode straddles two of them, which exercises multi-beat assembly far harder than the four-beat default. The narrow data path makes every operand pair reachable. All 256 pairs are run through add, subtract and multiply, and each result is compared with modulo-16 arithmetic. Directed programs cover the fetch address sequence and write timing, chaining through non-sequential next addresses, a result that overwrites its own operand, halt and unknown opcodes, and a restart in the middle of an instruction.

// File: rtl/mm4_pkg.sv
// Shared definitions for the four-address sequencer: control states and
// opcode values. Widths are left to the modules' parameters.
package mm4_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH,
        ST_CAPT,
        ST_RDA,
        ST_RDB,
        ST_EXEC,
        ST_WRITE,
        ST_REDIR
    } seq_st_t;

    localparam int OPC_HALT = 0;
    localparam int OPC_ADD  = 1;
    localparam int OPC_SUB  = 2;
    localparam int OPC_MUL  = 3;

endpackage

// File: rtl/mm4_alu.sv
// Combinational arithmetic unit. Assumes the opcode has already been
// screened; unknown opcodes yield zero, which is never written.
module mm4_alu #(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 8
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    import mm4_pkg::*;

    // Select the operation; results truncate to DATA_W bits.
    always_comb begin
        y = '0;
        if (opcode == OPC_W'(OPC_ADD))      y = a + b;
        else if (opcode == OPC_W'(OPC_SUB)) y = a - b;
        else if (opcode == OPC_W'(OPC_MUL)) y = a * b;
    end

endmodule

// File: rtl/mm4_ir.sv
// Instruction assembler. Shifts in one memory word per capture, most
// significant word first. On the final capture only the upper
// DATA_W-PAD bits are kept, so the register holds exactly the packed
// instruction. Assumes the instruction is wider than one data word.
module mm4_ir #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              cap_last,
    input  logic [DATA_W-1:0] rdata,
    output logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] res_a,
    output logic [ADDR_W-1:0] op1_a,
    output logic [ADDR_W-1:0] op2_a,
    output logic [ADDR_W-1:0] nxt_a
);
    localparam int INSTR_W = OPC_W + 4 * ADDR_W;
    localparam int BEATS   = (INSTR_W + DATA_W - 1) / DATA_W;
    localparam int PAD     = BEATS * DATA_W - INSTR_W;

    logic [INSTR_W-1:0] ir_q;

    // Shift captured words into the instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (cap_last)
            ir_q <= {ir_q[INSTR_W-DATA_W+PAD-1:0], rdata[DATA_W-1:PAD]};
        else if (cap)
            ir_q <= {ir_q[INSTR_W-DATA_W-1:0], rdata};
    end

    // Split the packed instruction into its fields.
    always_comb begin
        opcode = ir_q[INSTR_W-1 -: OPC_W];
        res_a  = ir_q[4*ADDR_W-1 -: ADDR_W];
        op1_a  = ir_q[3*ADDR_W-1 -: ADDR_W];
        op2_a  = ir_q[2*ADDR_W-1 -: ADDR_W];
        nxt_a  = ir_q[ADDR_W-1:0];
    end

endmodule

// File: rtl/mm4_seq.sv
// Control sequencer. Walks each instruction through fetch beats, final
// capture, operand reads, execute, write and redirect, and drives the
// memory port. Assumes one-cycle read latency and that a write issued in
// one cycle is visible to reads from the next cycle on.
module mm4_seq #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int OPC_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [ADDR_W-1:0]   res_a,
    input  logic [ADDR_W-1:0]   op1_a,
    input  logic [ADDR_W-1:0]   op2_a,
    input  logic [ADDR_W-1:0]   nxt_a,
    input  logic [DATA_W-1:0]   alu_y,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W-1:0]   opa,
    output logic                cap,
    output logic                cap_last,
    output logic                halted,
    output logic                illegal_op,
    output mm4_pkg::seq_st_t    st
);
    import mm4_pkg::*;

    localparam int INSTR_W = OPC_W + 4 * ADDR_W;
    localparam int BEATS   = (INSTR_W + DATA_W - 1) / DATA_W;
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    seq_st_t           st_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] ia_q;
    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] res_q;
    logic              ill_q;
    logic              op_known;

    // Classify the fetched opcode as computing or not.
    always_comb begin
        op_known = (opcode == OPC_W'(OPC_ADD)) ||
                   (opcode == OPC_W'(OPC_SUB)) ||
                   (opcode == OPC_W'(OPC_MUL));
    end

    // Advance the instruction state machine; start overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HALT;
            beat_q <= '0;
            ia_q   <= '0;
            opa_q  <= '0;
            res_q  <= '0;
            ill_q  <= 1'b0;
        end else if (start) begin
            st_q   <= ST_FETCH;
            beat_q <= '0;
            ia_q   <= start_addr;
            ill_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_FETCH: begin
                    if (beat_q == LAST_BEAT) begin
                        st_q   <= ST_CAPT;
                        beat_q <= '0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                ST_CAPT:  st_q <= ST_RDA;
                ST_RDA: begin
                    if (opcode == OPC_W'(OPC_HALT)) begin
                        st_q <= ST_HALT;
                    end else if (!op_known) begin
                        st_q  <= ST_HALT;
                        ill_q <= 1'b1;
                    end else begin
                        st_q <= ST_RDB;
                    end
                end
                ST_RDB: begin
                    opa_q <= mem_rdata;
                    st_q  <= ST_EXEC;
                end
                ST_EXEC: begin
                    res_q <= alu_y;
                    st_q  <= ST_WRITE;
                end
                ST_WRITE: st_q <= ST_REDIR;
                ST_REDIR: begin
                    ia_q   <= nxt_a;
                    beat_q <= '0;
                    st_q   <= ST_FETCH;
                end
                default:  st_q <= ST_HALT;
            endcase
        end
    end

    // Steer the memory address and controls from the current state.
    always_comb begin
        case (st_q)
            ST_FETCH: mem_addr = ia_q + ADDR_W'(beat_q);
            ST_RDA:   mem_addr = op1_a;
            ST_RDB:   mem_addr = op2_a;
            ST_WRITE: mem_addr = res_a;
            default:  mem_addr = ia_q;
        endcase
        mem_we     = (st_q == ST_WRITE);
        mem_wdata  = res_q;
        opa        = opa_q;
        cap        = (st_q == ST_FETCH) && (beat_q != '0);
        cap_last   = (st_q == ST_CAPT);
        halted     = (st_q == ST_HALT);
        illegal_op = ill_q;
        st         = st_q;
    end

endmodule

// File: rtl/mm4_core.sv
// Top of the four-address memory-to-memory sequencer. Connects the
// instruction assembler, sequencer and arithmetic unit to a single
// synchronous memory port with one cycle of read latency.
module mm4_core #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic              illegal_op
);
    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] res_a, op1_a, op2_a, nxt_a;
    logic [DATA_W-1:0] opa, alu_y;
    logic              cap, cap_last;
    mm4_pkg::seq_st_t  st;

    mm4_ir #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_last (cap_last),
        .rdata    (mem_rdata),
        .opcode   (opcode),
        .res_a    (res_a),
        .op1_a    (op1_a),
        .op2_a    (op2_a),
        .nxt_a    (nxt_a)
    );

    mm4_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .opcode     (opcode),
        .res_a      (res_a),
        .op1_a      (op1_a),
        .op2_a      (op2_a),
        .nxt_a      (nxt_a),
        .alu_y      (alu_y),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .opa        (opa),
        .cap        (cap),
        .cap_last   (cap_last),
        .halted     (halted),
        .illegal_op (illegal_op),
        .st         (st)
    );

    mm4_alu #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_alu (
        .opcode (opcode),
        .a      (opa),
        .b      (mem_rdata),
        .y      (alu_y)
    );

endmodule

// File: rtl/mm4_core_chk.sv
// Property checker for mm4_core, attached by bind. Observes the memory
// port, status outputs and the sequencer state.
module mm4_core_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input logic              illegal_op,
    input mm4_pkg::seq_st_t  st
);
    import mm4_pkg::*;

    // R2: start redirects the very next cycle and clears status
    p_start_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!halted && !illegal_op && mem_addr == $past(start_addr)));

    // R3: consecutive fetch beats read consecutive addresses
    p_fetch_consecutive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && $past(st) == ST_FETCH && !$past(start))
            |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R8: a stopped core never writes
    p_halted_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R9: the unknown-opcode flag only appears on a stopped core
    p_illegal_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> halted);

    // R10: each write lasts a single cycle
    p_single_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind mm4_core mm4_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .halted     (halted),
    .illegal_op (illegal_op),
    .st         (st)
);

// File: tb/mm4_core_test.sv
// Self-checking bench for mm4_core built with 4-bit data and 8-bit
// addresses (ten-word instructions) and a behavioural memory.
module mm4_core_test;
    localparam int DW    = 4;
    localparam int AW    = 8;
    localparam int IW    = 8 + 4 * AW;
    localparam int BEATS = (IW + DW - 1) / DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          halted;
    logic          illegal_op;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          bk_we = 1'b0;
    logic [AW-1:0] bk_addr = '0;
    logic [DW-1:0] bk_data = '0;
    int            wr_cnt = 0;
    int            checks = 0;
    int            failures = 0;

    always #10 clk = ~clk;

    mm4_core #(.DATA_W(DW), .ADDR_W(AW), .OPC_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .halted     (halted),
        .illegal_op (illegal_op)
    );

    // Synchronous memory with one-cycle read latency and a bench load port.
    always @(posedge clk) begin
        if (bk_we) mem[bk_addr] <= bk_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Count writes issued by the core.
    always @(posedge clk) if (mem_we) wr_cnt <= wr_cnt + 1;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        bk_we = 1'b1; bk_addr = AW'(a); bk_data = DW'(d);
        @(posedge clk);
        #1 bk_we = 1'b0;
    endtask

    task automatic put_instr(input int base, input int op, input int res,
                             input int a, input int b, input int nx);
        logic [IW-1:0] w;
        w = {8'(op), AW'(res), AW'(a), AW'(b), AW'(nx)};
        for (int k = 0; k < BEATS; k++) poke(base + k, w[IW-1-DW*k -: DW]);
    endtask

    task automatic wait_halt();
        int n;
        n = 0;
        while (!halted && n < 400) begin @(negedge clk); n++; end
        if (!halted) chk("R8 watchdog", 1'b0, 0, 1);
    endtask

    task automatic pulse_start(input int a);
        @(negedge clk);
        start = 1'b1; start_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input int a);
        pulse_start(a);
        wait_halt();
    endtask

    function automatic int expect_op(input int op, input int a, input int b);
        logic [DW-1:0] r;
        case (op)
            1: r = DW'(a + b);
            2: r = DW'(a - b);
            default: r = DW'(a * b);
        endcase
        return int'(r);
    endfunction

    // Global watchdog: a hung run fails and still prints the summary.
    initial begin
        #(20 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w0, bad;
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during and right after reset
        chk("R1 halted in reset", halted == 1'b1, int'(halted), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 halted after reset", halted == 1'b1 && illegal_op == 1'b0 && mem_we == 1'b0,
            int'({halted, illegal_op, mem_we}), 4);

        // R2 R3 R10: fetch sequence and write slot of one add
        put_instr(100, 1, 205, 200, 201, 120);
        put_instr(120, 0, 0, 0, 0, 0);
        poke(200, 7); poke(201, 12);
        pulse_start(100);
        bad = 0;
        for (int k = 0; k <= BEATS + 4; k++) begin
            if (k == 0) chk("R2 halted cleared", halted == 1'b0, int'(halted), 0);
            if (k < BEATS && mem_addr != AW'(100 + k)) begin
                chk("R3 fetch address", 1'b0, int'(mem_addr), 100 + k);
                bad++;
            end
            if (k < BEATS + 4 && mem_we) bad++;
            if (k == BEATS + 4)
                chk("R10 write slot", mem_we && mem_addr == 8'd205 && mem_wdata == 4'd3,
                    int'({mem_we, mem_addr, mem_wdata}), int'({1'b1, 8'd205, 4'd3}));
            @(negedge clk);
        end
        chk("R3 R10 no early write, ordered fetch", bad == 0, bad, 0);
        chk("R10 write lasts one cycle", mem_we == 1'b0, int'(mem_we), 0);
        wait_halt();
        chk("R4 add 7+12", mem[205] == 4'd3, int'(mem[205]), 3);

        // R7: chain through non-sequential next addresses
        put_instr(0, 1, 210, 200, 201, 40);
        put_instr(10, 1, 211, 200, 201, 10);
        put_instr(40, 2, 212, 200, 201, 60);
        put_instr(60, 0, 0, 0, 0, 0);
        poke(200, 9); poke(201, 3); poke(211, 0);
        w0 = wr_cnt;
        run(0);
        chk("R7 first result", mem[210] == 4'd12, int'(mem[210]), 12);
        chk("R7 second result via next field", mem[212] == 4'd6, int'(mem[212]), 6);
        chk("R7 sequential slot not run", mem[211] == 4'd0, int'(mem[211]), 0);
        chk("R10 one write per instruction", wr_cnt - w0 == 2, wr_cnt - w0, 2);

        // R8: halt opcode
        w0 = wr_cnt;
        run(60);
        chk("R8 halt no write", wr_cnt == w0, wr_cnt - w0, 0);
        chk("R8 halt no illegal", halted && !illegal_op, int'({halted, illegal_op}), 2);

        // R9: unknown opcode
        put_instr(80, 8'h07, 213, 200, 201, 0);
        poke(213, 5);
        w0 = wr_cnt;
        run(80);
        chk("R9 illegal flagged", halted && illegal_op, int'({halted, illegal_op}), 3);
        chk("R9 result untouched", mem[213] == 4'd5 && wr_cnt == w0, int'(mem[213]), 5);
        put_instr(80, 8'hFF, 213, 200, 201, 0);
        run(80);
        chk("R9 opcode 0xFF flagged", illegal_op == 1'b1 && mem[213] == 4'd5, int'(illegal_op), 1);

        // R2: a new start clears the illegal flag
        run(60);
        chk("R2 start clears illegal", illegal_op == 1'b0, int'(illegal_op), 0);

        // R11: result overwrites its own first operand
        put_instr(0, 1, 200, 200, 201, 10);
        put_instr(10, 0, 0, 0, 0, 0);
        poke(200, 5); poke(201, 6);
        run(0);
        chk("R11 aliased result", mem[200] == 4'd11, int'(mem[200]), 11);

        // R12: restart mid-instruction abandons the write
        put_instr(0, 1, 202, 200, 201, 10);
        poke(202, 9);
        w0 = wr_cnt;
        pulse_start(0);
        repeat (BEATS + 2) @(negedge clk);
        pulse_start(60);
        wait_halt();
        chk("R12 abandoned instruction silent", mem[202] == 4'd9 && wr_cnt == w0,
            int'(mem[202]), 9);

        // R4 R5 R6: exhaustive operand sweep for each computing opcode
        for (int op = 1; op <= 3; op++) begin
            put_instr(0, op, 202, 200, 201, 10);
            w0 = wr_cnt;
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    poke(200, a); poke(201, b);
                    run(0);
                    chk(op == 1 ? "R4 add" : (op == 2 ? "R5 sub" : "R6 mul"),
                        mem[202] == DW'(expect_op(op, a, b)),
                        int'(mem[202]), expect_op(op, a, b));
                end
            end
            chk("R10 write count in sweep", wr_cnt - w0 == 256, wr_cnt - w0, 256);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule